// File: doc/BRIEF.md
# Single-Wire Consumer-Control Frame Transmitter

This block sends one frame on a shared open-drain consumer-electronics control line, where every node can only pull the wire low and the line reads high when nobody drives it. A client loads a byte buffer and a byte count and pulses a send strobe. The block then waits until the line has been free for the requested number of bit periods. It drives a long start pulse and then sends each byte as ten timed slots. The first byte of a frame is the header: the initiator address sits in its upper nibble and the destination in its lower nibble.

While it sends the first four header bits, the block checks whether another initiator has pulled the line low under one of its own logical 1 bits. At the end of each byte it reads the acknowledge slot. A broadcast frame reads that slot with the inverted sense. The block also watches for an error pulse from another node at the end of every bit it samples. When it finishes, it pulses `done` with a 2-bit outcome code. If arbitration is lost, the outcome code is the only handoff to the receive path.

All durations are counted in ticks of a 1 µs enable, so the system clock can run at any frequency. The line input is resynchronised inside the block.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset `drive_low`, `busy` and `done` are 0 and `status` is 0.
- R2: The start pulse begins only after the line has been seen high without a break for (`sft_periods`+1) whole bit periods of 2.4 ms. A low level during that wait restarts the count from zero.
- R3: The start pulse drives the line low for 3.7 ms, and the first data slot begins 4.5 ms after the start pulse began.
- R4: Each slot lasts 2.4 ms from one falling edge to the next. A 0 is driven low for 1.5 ms and a 1 for 0.6 ms. Every byte takes ten slots in this order: eight data bits with bit 7 first, then the end flag (1 only on the last byte), then the acknowledge slot, which is always driven as a 1. Byte k is taken from `tx_data[8k+7:8k]`.
- R5: When the block sends a 1 in one of the first four slots of byte 0 and the line is low 0.85 ms after that slot's falling edge, it stops driving, pulses `done` with `status` 2 and sends no further slot.
- R6: For a directed frame (destination nibble `tx_data[3:0]` not 15), the acknowledge slot sampled at 0.85 ms counts as accepted when the line is low. If it is high, the block ends after that slot with `status` 1 and sends none of the remaining bytes.
- R7: For a broadcast frame (`tx_data[3:0]` equal to 15), a low line in the acknowledge slot means rejection (`status` 1) and a high line means acceptance.
- R8: If the line is still low at the end of any slot whose level was sampled, the block stops driving and waits for the line to return high. It then pulses `done` with `status` 3.
- R9: After the acknowledge slot of the last byte has been accepted, the block pulses `done` with `status` 0. `status` changes only in a cycle in which `done` is 1.
- R10: `done` lasts one cycle. `busy` rises the cycle after an accepted strobe and falls in the cycle `done` is 1. A strobe while `busy` is 1 has no effect on the frame on the line.
- R11: `drive_low` is never 1 while `busy` is 0.
- R12: A strobe with `tx_len` equal to 0 pulses `done` with `status` 0 on the next cycle and does not drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send | input | 1 | Start strobe; buffer, length and free time are captured with it |
| tx_len | input | 5 | Number of bytes to send, 0 to 16 |
| tx_data | input | 128 | Frame bytes; byte k in bits 8k+7..8k |
| sft_periods | input | 4 | Free-time requirement in bit periods (counts one more) |
| tick_us | input | 1 | One-cycle enable every microsecond |
| line_in | input | 1 | Raw level of the shared line |
| drive_low | output | 1 | Pull the line low when 1 |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Outcome: 0 success, 1 not acknowledged, 2 arbitration lost, 3 error pulse seen |

## Verification
The bench models the other nodes on the wire. A follower pulls the acknowledge slot low, an opposing initiator overwrites a header 1 bit, and a node stretches an acknowledge pulse past the slot end. It measures every pulse the block drives against a list built from the frame bytes. A design that inverted the broadcast acknowledge sense, or that continued after a rejected byte, would produce a wrong status or extra pulses. Pulling the line low during the free-time wait catches a counter that fails to restart, because the start pulse would then appear too early. The stretched-pulse case checks that completion waits for the line to rise, not just for the slot boundary.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    TXS_OK     = 2'd0,
    TXS_NACK   = 2'd1,
    TXS_ARB    = 2'd2,
    TXS_LOWDRV = 2'd3
  } tx_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_BIT,
    ST_HOLD
  } tx_state_e;

endpackage

// File: rtl/cec_tx_sync.sv
module cec_tx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cec_tx_phase.sv
module cec_tx_phase #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cec_tx_bitsel.sv
module cec_tx_bitsel #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NBYTES*8-1:0] frame,
  input  logic [IDX_W-1:0]    bidx,
  input  logic [3:0]          sidx,
  input  logic                last_byte,
  output logic                bit_val,
  output logic                sampled
);
  logic [7:0] bytes [NBYTES];
  logic [7:0] cur;

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign bytes[g] = frame[g*8 +: 8];
  end

  assign cur = bytes[bidx];

  always_comb begin
    if (sidx < 4'd8)       bit_val = cur[3'd7 - sidx[2:0]];
    else if (sidx == 4'd8) bit_val = last_byte;
    else                   bit_val = 1'b1;
    sampled = (sidx == 4'd9) || ((bidx == '0) && (sidx < 4'd4) && bit_val);
  end
endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES   = 16,
  parameter int SFT_W       = 4,
  parameter int T_START_LOW = 3700,
  parameter int T_START_ALL = 4500,
  parameter int T_ZERO_LOW  = 1500,
  parameter int T_ONE_LOW   = 600,
  parameter int T_BIT_ALL   = 2400,
  parameter int T_SAMPLE    = 850
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   send,
  input  logic [$clog2(MAX_BYTES+1)-1:0] tx_len,
  input  logic [MAX_BYTES*8-1:0] tx_data,
  input  logic [SFT_W-1:0]       sft_periods,
  input  logic                   tick_us,
  input  logic                   line_in,
  output logic                   drive_low,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             status
);
  localparam int LEN_W = $clog2(MAX_BYTES+1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int PH_W  = $clog2(T_START_ALL+1);

  tx_state_e             state_q, state_d;
  logic [MAX_BYTES*8-1:0] frame_q, frame_d;
  logic [LEN_W-1:0]      len_q, len_d;
  logic [SFT_W-1:0]      sft_q, sft_d;
  logic [SFT_W:0]        pcnt_q, pcnt_d;
  logic [IDX_W-1:0]      bidx_q, bidx_d;
  logic [3:0]            sidx_q, sidx_d;
  logic                  nack_q, nack_d;
  logic                  done_q, done_d;
  tx_status_e            status_q, status_d;

  logic            line_s, ph_clr, bit_val, sampled, last_byte, bcast;
  logic [PH_W-1:0] ph;
  logic            at_sample, end_bit, end_start;

  cec_tx_sync u_sync (.clk(clk), .rst_n(rst_n), .d_async(line_in), .q(line_s));

  cec_tx_phase #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(tick_us), .clr(ph_clr), .cnt(ph)
  );

  cec_tx_bitsel #(.NBYTES(MAX_BYTES), .IDX_W(IDX_W)) u_bitsel (
    .frame(frame_q), .bidx(bidx_q), .sidx(sidx_q), .last_byte(last_byte),
    .bit_val(bit_val), .sampled(sampled)
  );

  assign last_byte = (LEN_W'(bidx_q) + 1'b1) == len_q;
  assign bcast     = frame_q[3:0] == 4'hF;
  assign at_sample = tick_us && (ph == PH_W'(T_SAMPLE));
  assign end_bit   = tick_us && (ph == PH_W'(T_BIT_ALL - 1));
  assign end_start = tick_us && (ph == PH_W'(T_START_ALL - 1));

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    len_d    = len_q;
    sft_d    = sft_q;
    pcnt_d   = pcnt_q;
    bidx_d   = bidx_q;
    sidx_d   = sidx_q;
    nack_d   = nack_q;
    done_d   = 1'b0;
    status_d = status_q;
    ph_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ph_clr = 1'b1;
        if (send) begin
          if (tx_len == '0) begin
            done_d   = 1'b1;
            status_d = TXS_OK;
          end else begin
            frame_d = tx_data;
            len_d   = tx_len;
            sft_d   = sft_periods;
            pcnt_d  = '0;
            bidx_d  = '0;
            sidx_d  = '0;
            nack_d  = 1'b0;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!line_s) begin
          ph_clr = 1'b1;
          pcnt_d = '0;
        end else if (end_bit) begin
          ph_clr = 1'b1;
          if (pcnt_q == {1'b0, sft_q}) state_d = ST_START;
          else                         pcnt_d  = pcnt_q + 1'b1;
        end
      end
      ST_START: begin
        if (end_start) begin
          ph_clr  = 1'b1;
          state_d = ST_BIT;
        end
      end
      ST_BIT: begin
        if (at_sample && sampled) begin
          if (sidx_q == 4'd9) begin
            nack_d = bcast ? !line_s : line_s;
          end else if (!line_s) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            status_d = TXS_ARB;
          end
        end else if (end_bit) begin
          ph_clr = 1'b1;
          if (sampled && !line_s) begin
            state_d = ST_HOLD;
          end else if (sidx_q == 4'd9 && nack_q) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            status_d = TXS_NACK;
          end else if (sidx_q == 4'd9 && last_byte) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            status_d = TXS_OK;
          end else if (sidx_q == 4'd9) begin
            sidx_d = '0;
            bidx_d = bidx_q + 1'b1;
          end else begin
            sidx_d = sidx_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        ph_clr = 1'b1;
        if (line_s) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          status_d = TXS_LOWDRV;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= '0;
      len_q    <= '0;
      sft_q    <= '0;
      pcnt_q   <= '0;
      bidx_q   <= '0;
      sidx_q   <= '0;
      nack_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= TXS_OK;
    end else begin
      state_q  <= state_d;
      frame_q  <= frame_d;
      len_q    <= len_d;
      sft_q    <= sft_d;
      pcnt_q   <= pcnt_d;
      bidx_q   <= bidx_d;
      sidx_q   <= sidx_d;
      nack_q   <= nack_d;
      done_q   <= done_d;
      status_q <= status_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: drive_low = ph < PH_W'(T_START_LOW);
      ST_BIT:   drive_low = ph < (bit_val ? PH_W'(T_ONE_LOW) : PH_W'(T_ZERO_LOW));
      default:  drive_low = 1'b0;
    endcase
  end

  assign busy   = state_q != ST_IDLE;
  assign done   = done_q;
  assign status = status_q;
endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       send,
  input logic       busy,
  input logic       done,
  input logic       drive_low,
  input logic [1:0] status
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low);                                  // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                        // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                        // R10
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                  // R10
  AST_BUSY_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(send));                           // R10
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));                             // R9
endmodule

bind cec_frame_tx cec_frame_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .send(send), .busy(busy), .done(done),
  .drive_low(drive_low), .status(status)
);

// File: tb/cec_frame_tx_tb_top.sv
module cec_frame_tx_tb_top;
  localparam int NB  = 4;
  localparam int SL  = 370, SA = 450, ZL = 150, OL = 60, BA = 240, SP = 85;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        send = 1'b0;
  logic [2:0]  tx_len = '0;
  logic [31:0] tx_data = '0;
  logic [3:0]  sft = '0;
  logic        tick = 1'b0;
  logic        ext_low = 1'b0;
  logic        hold_low = 1'b0;
  logic        line;
  logic        drive_low, busy, done;
  logic [1:0]  status;

  assign line = ~(drive_low | ext_low | hold_low);

  cec_frame_tx #(.MAX_BYTES(NB), .SFT_W(4), .T_START_LOW(SL), .T_START_ALL(SA),
                 .T_ZERO_LOW(ZL), .T_ONE_LOW(OL), .T_BIT_ALL(BA), .T_SAMPLE(SP)) dut_i (
    .clk(clk), .rst_n(rst_n), .send(send), .tx_len(tx_len), .tx_data(tx_data),
    .sft_periods(sft), .tick_us(tick), .line_in(line), .drive_low(drive_low),
    .busy(busy), .done(done), .status(status)
  );

  int checks = 0, failures = 0;
  int tick_no = 0, ext_cnt = 0, edge_cnt = 0, done_cnt = 0;
  int t_fall = 0, last_fall = 0, cur_gap = 0;
  int start_lo = 0, start_hi = 0;
  int r_ack = 0, r_arb = -1, r_ld = -1;
  logic d_prev = 1'b0;

  int    exp_w[$];
  int    exp_g[$];
  string exp_tag[$];
  int    exp_st[$];
  string exp_st_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bus monitor, other-node responder and scoreboard (all at the falling clock edge)
  always @(negedge clk) begin
    if (tick) begin
      tick_no++;
      if (ext_cnt > 0) ext_cnt--;
    end
    if (!busy) edge_cnt = 0;
    if (drive_low && !d_prev) begin
      if (edge_cnt == 0) begin
        check(tick_no >= start_lo && tick_no <= start_hi, "R2", "start pulse time",
              tick_no, start_lo);
        cur_gap = 0;
      end else begin
        int s;
        s = edge_cnt - 1;
        cur_gap = tick_no - last_fall;
        if (s % 10 == 9 && r_ack[s/10]) ext_cnt = 150;
        if (s == r_arb) ext_cnt = 150;
        if (s == r_ld)  ext_cnt = 400;
      end
      last_fall = tick_no;
      t_fall = tick_no;
      edge_cnt++;
    end
    ext_low = ext_cnt > 0;
    if (!drive_low && d_prev) begin
      if (exp_w.size() == 0) begin
        check(1'b0, "R4", "unexpected pulse width", tick_no - t_fall, 0);
      end else begin
        int w, g;
        string tg;
        w = exp_w.pop_front();
        g = exp_g.pop_front();
        tg = exp_tag.pop_front();
        check(tick_no - t_fall == w, tg, "low width", tick_no - t_fall, w);
        if (g != 0) check(cur_gap == g, tg, "fall-to-fall gap", cur_gap, g);
      end
    end
    d_prev = drive_low;
    if (done) begin
      done_cnt++;
      check(!busy, "R10", "busy at done", busy, 0);
      if (exp_st.size() == 0) begin
        check(1'b0, "R10", "unexpected done", status, 0);
      end else begin
        int es;
        string st;
        es = exp_st.pop_front();
        st = exp_st_tag.pop_front();
        check(status == 2'(es), st, "status", status, es);
      end
    end
    tick = ~tick;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_frame(input logic [31:0] data, input int len, input int sft_v,
                           input int n_slots, input int est, input string req,
                           input int ack_m, input int arb_s, input int ld_s,
                           input bit yield, input bit poke);
    int dc;
    r_ack = ack_m; r_arb = arb_s; r_ld = ld_s;
    if (len > 0) begin
      exp_w.push_back(SL); exp_g.push_back(0); exp_tag.push_back("R3");
    end
    for (int s = 0; s < n_slots; s++) begin
      int by, pos;
      bit b;
      by = s / 10; pos = s % 10;
      if (pos < 8)       b = data[by*8 + 7 - pos];
      else if (pos == 8) b = (by == len - 1);
      else               b = 1'b1;
      exp_w.push_back(b ? OL : ZL);
      exp_g.push_back(s == 0 ? SA : BA);
      exp_tag.push_back(s == 0 ? "R3" : "R4");
    end
    exp_st.push_back(est); exp_st_tag.push_back(req);
    dc = done_cnt;
    tx_data = data; tx_len = 3'(len); sft = 4'(sft_v); send = 1'b1;
    start_lo = tick_no + (sft_v + 1) * BA - 1;
    start_hi = start_lo + 5;
    step(1);
    send = 1'b0;
    step(1);
    if (len > 0) check(busy == 1'b1, "R10", "busy after strobe", busy, 1);
    if (yield) begin
      step(200);
      hold_low = 1'b1;
      step(600);
      hold_low = 1'b0;
      start_lo = tick_no + (sft_v + 1) * BA - 1;
      start_hi = start_lo + 5;
    end
    if (poke) begin
      for (int i = 0; i < 20000 && edge_cnt < 4; i++) step(1);
      tx_data = 32'hFFFF_FFFF; tx_len = 3'd4; send = 1'b1;   // R10: ignored while busy
      step(1);
      send = 1'b0;
    end
    for (int i = 0; i < 30000 && done_cnt == dc; i++) step(1);
    check(done_cnt == dc + 1, req, "done count", done_cnt - dc, 1);
    if (ld_s >= 0) check(tick_no - last_fall >= 400, "R8", "done after line high",
                         tick_no - last_fall, 400);
    step(1400);
    check(exp_w.size() == 0, req, "missing pulses", exp_w.size(), 0);
    exp_w.delete(); exp_g.delete(); exp_tag.delete();
    r_ack = 0; r_arb = -1; r_ld = -1;
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(2);
    check(drive_low == 1'b0, "R1", "drive_low after reset", drive_low, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(status == 2'd0, "R1", "status after reset", status, 0);
    // R9 R10: directed one byte, acknowledged, second strobe mid-frame
    run_frame(32'h0000_0004, 1, 1, 10, 0, "R9", 1, -1, -1, 1'b0, 1'b1);
    // R2 R4: two bytes, header 1 in arbitration field, line held low during wait
    run_frame(32'h0000_A315, 2, 2, 20, 0, "R2", 3, -1, -1, 1'b1, 1'b0);
    // R6: directed, first byte not acknowledged, stop before byte 1
    run_frame(32'h0000_5A04, 2, 0, 10, 1, "R6", 0, -1, -1, 1'b0, 1'b0);
    // R7: broadcast, nobody pulls, accepted
    run_frame(32'h0000_364F, 2, 0, 20, 0, "R7", 0, -1, -1, 1'b0, 1'b0);
    // R7: broadcast, a node pulls the acknowledge, rejected
    run_frame(32'h0000_004F, 1, 0, 10, 1, "R7", 1, -1, -1, 1'b0, 1'b0);
    // R5: opposing initiator overwrites header slot 2
    run_frame(32'h0000_0030, 2, 0, 3, 2, "R5", 0, 2, -1, 1'b0, 1'b0);
    // R8: acknowledge stretched past the slot end
    run_frame(32'h0000_1104, 2, 0, 10, 3, "R8", 0, -1, 9, 1'b0, 1'b0);
    // R12: zero length
    run_frame(32'h0000_0000, 0, 0, 0, 0, "R12", 0, -1, -1, 1'b0, 1'b0);
    check(drive_low == 1'b0 && !busy, "R11", "quiet when idle", drive_low, 0);
    check(exp_st.size() == 0, "R10", "pending outcomes", exp_st.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", done_cnt, 8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule